// File: doc/BRIEF.md
# OS Match Timer with Watchdog Reset

This block is a free-running 32-bit time base that has four 32-bit compare channels. The counter advances by one on every clock cycle in which the `tick_en` strobe is high. The strobe comes from an external prescaler. Software can write the counter at any time, and counting resumes from the loaded value.

Each compare channel watches the counter. When an increment carries the counter onto a channel's compare value, and that channel is enabled, the channel latches a pending flag and drives its interrupt line. Software acknowledges a pending flag by writing a one to it.

The last compare channel has a second use as a one-shot watchdog. If software has armed the watchdog and the counter reaches that channel's value, the block issues a single-cycle system reset request and disarms itself. A fresh software write is needed to arm it again.

Access is through a plain single-cycle register port: a write strobe, a byte address and write data. Read data is combinational from the address. There is no data stream at the edge of this block, so no valid/ready handshake is used. All interrupt and reset outputs are plain level or pulse pins.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all four compare registers, the interrupt-enable register, the watchdog register and the pending flags read as zero, and `irq_o` and `wdt_rst_req` are low.
- R2: The counter (byte offset 0x10) increments by one on each rising edge where `tick_en` is high. It wraps from 0xFFFFFFFF to 0 and holds its value when `tick_en` is low.
- R3: A write to offset 0x10 loads the written value at that edge, even if `tick_en` is high in the same cycle. Later ticks count on from the loaded value, and a read of 0x10 returns the current count.
- R4: The compare registers for channels 0, 1, 2 and 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. Each holds a full 32-bit value that reads back as written.
- R5: Suppose a tick moves the counter to a value equal to compare register n, and enable bit n is set. Then pending bit n sets at that same edge, and `irq_o[n]` is high from that edge on. A counter load whose value equals a compare register does not count as a match.
- R6: If enable bit n is clear, a match on channel n leaves pending bit n and `irq_o[n]` unchanged.
- R7: The pending flags read at offset 0x14 in bits 3:0, with bit n belonging to channel n. Writing 0x14 clears every pending bit written as one, which lowers that interrupt line. Ones written to bits that are not pending have no effect.
- R8: If a match sets pending bit n in the same cycle that software writes a one to clear bit n, the bit stays set.
- R9: The interrupt-enable register at offset 0x1C stores bits 11:0 of a write, and bits 31:12 read as zero. Bit n (n = 0..3) enables channel n.
- R10: The watchdog register at offset 0x18 stores and returns 32 bits. If its bit 0 is set when channel 3 matches, whatever the state of enable bit 3, `wdt_rst_req` is high for exactly the one cycle after that edge and the register becomes zero.
- R11: If watchdog bit 0 is clear when channel 3 matches, `wdt_rst_req` stays low and the watchdog register keeps its value.
- R12: Reads of any other byte offset, including misaligned ones, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe from an external prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 4 | Per-channel interrupt, high while the channel's pending bit is set |
| wdt_rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
On every cycle, the embedded assertions check several properties:
- the counter steps by exactly one per tick, loads a written value and otherwise holds still;
- compare registers change only when written;
- a pending bit can rise only while its enable was set, and can fall only under a write that targets it;
- the reset request is a lone pulse, and the watchdog register is zero whenever the request is high.

Some behaviour can only be shown by the bench's scenarios. These are the exact edge on which a match lands relative to the counter value, the rule that a load onto the compare value is not a match, and the priority of a set over a simultaneous clear. They also include the watchdog firing regardless of the interrupt enable, and the masking of the enable register and of unmapped offsets.

// File: rtl/omt_pkg.sv
package omt_pkg;
  localparam int DATA_W   = 32;
  localparam int N_CHAN   = 4;
  localparam int IEN_W    = 12;
  // byte offsets of the register map; channel k compare sits at CMP_BASE + 4*k
  localparam int CMP_BASE = 'h00;
  localparam int CNT_OFS  = 'h10;
  localparam int PEND_OFS = 'h14;
  localparam int WDOG_OFS = 'h18;
  localparam int IEN_OFS  = 'h1C;
endpackage

// File: rtl/omt_counter.sv
module omt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cnt_inc,
  output logic          advance
);
  assign cnt_inc = cnt_q + DW'(1);
  assign advance = tick_en && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (tick_en) cnt_q <= cnt_inc;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load) |=> (cnt_q == $past(cnt_q) + DW'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(cnt_q));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/omt_match_chan.sv
module omt_match_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          advance,
  input  logic [DW-1:0] cnt_inc,
  output logic [DW-1:0] cmp_q,
  output logic          hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp_q <= '0;
    else if (wr) cmp_q <= wdata;
  end

  // a match is the counter stepping onto the compare value
  assign hit = advance && (cnt_inc == cmp_q);

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cmp_q));
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import omt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = 8,
  parameter int NCH  = N_CHAN,
  parameter int IEW  = IEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [NCH-1:0] irq_o,
  output logic          wdt_rst_req
);
  localparam int WDG_CH = NCH - 1;
  localparam logic [AW-1:0] A_CNT  = AW'(CNT_OFS);
  localparam logic [AW-1:0] A_PEND = AW'(PEND_OFS);
  localparam logic [AW-1:0] A_WDOG = AW'(WDOG_OFS);
  localparam logic [AW-1:0] A_IEN  = AW'(IEN_OFS);

  logic [DW-1:0]  cnt_q, cnt_inc;
  logic           advance;
  logic [DW-1:0]  cmp_q [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] pend_q, pend_clr;
  logic [IEW-1:0] ien_q;
  logic [DW-1:0]  wdog_q;
  logic           wr_cnt, wr_pend, wr_wdog, wr_ien;

  assign wr_cnt  = reg_we && (reg_addr == A_CNT);
  assign wr_pend = reg_we && (reg_addr == A_PEND);
  assign wr_wdog = reg_we && (reg_addr == A_WDOG);
  assign wr_ien  = reg_we && (reg_addr == A_IEN);

  omt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_cnt),
    .load_val(reg_wdata), .cnt_q(cnt_q), .cnt_inc(cnt_inc), .advance(advance)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic wr_cmp;
    assign wr_cmp = reg_we && (reg_addr == AW'(CMP_BASE + 4 * k));
    omt_match_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wdata(reg_wdata),
      .advance(advance), .cnt_inc(cnt_inc), .cmp_q(cmp_q[k]), .hit(hit[k])
    );

    // R6
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[k]) |-> $past(ien_q[k]));
    // R7
    pend_fall_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o[k]) |-> $past(wr_pend && reg_wdata[k]));
  end

  // write-one-to-clear, restricted to bits already pending; a new match wins
  assign pend_clr = wr_pend ? (reg_wdata[NCH-1:0] & pend_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | (hit & ien_q[NCH-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= reg_wdata[IEW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdog_q      <= '0;
      wdt_rst_req <= 1'b0;
    end else if (hit[WDG_CH] && wdog_q[0]) begin
      wdog_q      <= '0;
      wdt_rst_req <= 1'b1;
    end else begin
      wdt_rst_req <= 1'b0;
      if (wr_wdog) wdog_q <= reg_wdata;
    end
  end

  assign irq_o = pend_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CNT)  reg_rdata = cnt_q;
    if (reg_addr == A_PEND) reg_rdata = {{(DW-NCH){1'b0}}, pend_q};
    if (reg_addr == A_WDOG) reg_rdata = wdog_q;
    if (reg_addr == A_IEN)  reg_rdata = {{(DW-IEW){1'b0}}, ien_q};
    for (int k = 0; k < NCH; k++)
      if (reg_addr == AW'(CMP_BASE + 4 * k)) reg_rdata = cmp_q[k];
  end

  // R10
  wdog_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (wdog_q == '0));
  // R10
  rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);
  // R11
  no_req_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wdog_q[0]) |-> !wdt_rst_req);
endmodule

// File: tb/test_os_match_timer.sv
module test_os_match_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  irq_o;
  logic        wdt_rst_req;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_match_timer i_os_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wdt_rst_req(wdt_rst_req)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h00, 32'h1111_1111, 32'h1111_1111, 4'd4},   // R4
    '{8'h04, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd4},   // R4
    '{8'h08, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 4'd4},   // R4
    '{8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd4},   // R4
    '{8'h1C, 32'hFFFF_FFFF, 32'h0000_0FFF, 4'd9},   // R9
    '{8'h18, 32'h0000_0006, 32'h0000_0006, 4'd10},  // R10
    '{8'h10, 32'h1234_5678, 32'h1234_5678, 4'd3},   // R3
    '{8'h24, 32'hCAFE_F00D, 32'h0000_0000, 4'd12},  // R12
    '{8'h02, 32'hBEEF_0001, 32'h0000_0000, 4'd12}   // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; tick_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (VECS[i]) begin
      rd(VECS[i].addr, v); check("R1", v, 32'h0);
    end
    rd(8'h14, v); check("R1", v, 32'h0);
    check("R1", {27'h0, wdt_rst_req, irq_o}, 32'h0);

    // register table, counting stopped
    foreach (VECS[i]) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, v);
      check($sformatf("R%0d", VECS[i].req), v, VECS[i].exp);
    end
    rd(8'h00, v); check("R12", v, 32'h1111_1111);
    rd(8'h04, v); check("R12", v, 32'hA5A5_A5A5);

    wr(8'h1C, 32'h0); wr(8'h18, 32'h0);

    // R2 counting, hold, wrap
    wr(8'h10, 32'd5);
    tick_en = 1'b1; repeat (3) @(negedge clk); tick_en = 1'b0;
    rd(8'h10, v); check("R2", v, 32'd8);
    repeat (2) @(negedge clk);
    rd(8'h10, v); check("R2", v, 32'd8);
    wr(8'h10, 32'hFFFF_FFFF);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    rd(8'h10, v); check("R2", v, 32'h0);

    // R3 load wins over a tick in the same cycle
    tick_en = 1'b1;
    wr(8'h10, 32'd100);
    rd(8'h10, v); check("R3", v, 32'd100);
    @(negedge clk); tick_en = 1'b0;
    rd(8'h10, v); check("R3", v, 32'd101);

    // R5 match sets pending on the edge the counter reaches the value
    wr(8'h1C, 32'hF);
    wr(8'h04, 32'd50);
    wr(8'h10, 32'd48);
    tick_en = 1'b1;
    @(negedge clk);
    check("R5", {28'h0, irq_o}, 32'h0);
    @(negedge clk); tick_en = 1'b0;
    check("R5", {28'h0, irq_o}, 32'h2);
    rd(8'h14, v); check("R5", v, 32'h2);

    // R7 clearing non-pending bits does nothing; clearing bit 1 lowers irq
    wr(8'h14, 32'hD);
    rd(8'h14, v); check("R7", v, 32'h2);
    wr(8'h14, 32'h2);
    rd(8'h14, v); check("R7", v, 32'h0);
    check("R7", {28'h0, irq_o}, 32'h0);

    // R5 loading the compare value is not a match
    wr(8'h10, 32'd50);
    @(negedge clk);
    check("R5", {28'h0, irq_o}, 32'h0);

    // R6 disabled channel records nothing
    wr(8'h1C, 32'hD);
    wr(8'h10, 32'd49);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    rd(8'h14, v); check("R6", v, 32'h0);
    check("R6", {28'h0, irq_o}, 32'h0);

    // R8 set beats clear in the same cycle
    wr(8'h1C, 32'hF);
    wr(8'h10, 32'd49);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    wr(8'h10, 32'd49);
    tick_en = 1'b1;
    wr(8'h14, 32'h2);
    tick_en = 1'b0;
    rd(8'h14, v); check("R8", v, 32'h2);
    check("R8", {28'h0, irq_o}, 32'h2);
    wr(8'h14, 32'hF);

    // R10 armed watchdog fires on channel 3 even with its enable clear
    wr(8'h1C, 32'h7);
    wr(8'h0C, 32'd200);
    wr(8'h18, 32'h1);
    wr(8'h10, 32'd199);
    tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    check("R10", {31'h0, wdt_rst_req}, 32'h1);
    rd(8'h18, v); check("R10", v, 32'h0);
    rd(8'h14, v); check("R10", v, 32'h0);
    @(negedge clk);
    check("R10", {31'h0, wdt_rst_req}, 32'h0);

    // R11 unarmed watchdog keeps its value and stays quiet
    wr(8'h18, 32'h2);
    wr(8'h10, 32'd199);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    check("R11", {31'h0, wdt_rst_req}, 32'h0);
    rd(8'h18, v); check("R11", v, 32'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule